// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block sends frames that a host has queued in memory as rings of linked transmit descriptors. It serves two transmit queues. Each queue has a ring pointer register that the host writes and can read back. A one-cycle start pulse on a queue makes the engine walk that queue's ring exactly once. The walk begins at the ring pointer and follows each descriptor's next pointer until that pointer comes back to the ring pointer.

A descriptor takes 16 bytes, little-endian. The control word is at +0, with the ownership flag in bit 31. A reserved halfword is at +4 and the byte count is at +6, so the count is bits [31:16] of the word at +4. The buffer address is at +8 and the next pointer is at +12. The engine processes every descriptor whose ownership flag is set. If the byte count lies between 1 and 2047, the engine fetches the buffer one 32-bit word at a time and streams it out as bytes. It then writes the control word back with the flag cleared and pulses that queue's completion cause. A count of 0, or of 2048 and above, is completed the same way, but no frame is sent. A descriptor whose flag is clear is passed over.

The memory master issues one word request at a time and holds it until acknowledged. Read data arrives together with the acknowledge. Buffers are assumed to be word aligned.

Top module: `txring_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `cause_pulse` and `busy` are low, and both ring pointers read 0.
- R2: A pulse on `ptr_we[q]` loads `ptr_wdata` into queue q's ring pointer, which reads back on `ring_ptr[32*q +: 32]` from the next cycle.
- R3: A walk visits descriptors from the ring pointer along the next pointers, in that order. It ends once the next pointer of the visited descriptor equals the ring pointer that was captured when the walk started.
- R4: A descriptor with bit 31 of its control word clear is only read at +0 and +12. It produces no frame, no write and no cause.
- R5: A descriptor with bit 31 set and a byte count of 1 to 2047 is sent as exactly that many bytes. Buffer byte k is taken from bits [8*(k%4) +: 8] of the word at buffer+4*(k/4), and `tx_last` is high only on the final byte.
- R6: A descriptor with bit 31 set and a byte count of 0 or of 2048 and above sends no byte and no buffer read, but is still written back and signalled.
- R7: Every processed descriptor gets exactly one write, to its +0 word. The write carries the original control word with bit 31 cleared and all other bits kept. No other memory word is written.
- R8: Each processed descriptor of queue q gives one single-cycle pulse on `cause_pulse` bit (3 - q): bit 3 for queue 0 and bit 2 for queue 1. No other bit pulses.
- R9: A start pulse that arrives while a walk is running is held and served after that walk ends. When both queues are pending, queue 0 is walked first.
- R10: A walk stops after 256 descriptor visits even if the next pointer never returns to the ring pointer.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R12: While `mem_req` is high and `mem_ack` low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 2 | Per-queue ring pointer write strobe |
| ptr_wdata | input | 32 | Ring pointer write value |
| start | input | 2 | Per-queue start pulse |
| ring_ptr | output | 64 | Ring pointers, queue q at bits [32*q +: 32] |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| cause_pulse | output | 4 | Completion cause pulses |
| busy | output | 1 | A walk is running or a start is pending |

## Verification
A ring pointer can be read back one cycle after its write. `busy` rises one cycle after a start pulse. A cause pulse follows the acknowledged write-back by one cycle. A frame byte and a memory transfer each complete on the clock edge where valid and ready (or request and acknowledge) are both high.

The bench drives `tx_ready` and the acknowledge at random on the falling edge. On that same falling edge it records any transfer that the next rising edge will complete, so every byte, read, write and pulse is counted exactly once, whatever the stall pattern. Results are compared only once `busy` has fallen. The frame bytes, the read and write counts, the per-bit cause counts and the full memory image are checked against a bench model of the walk.

// File: rtl/txr_pkg.sv
// Shared types of the transmit descriptor ring engine.
// Assumes 32-bit descriptor words at offsets 0, 4, 8 and 12.
package txr_pkg;
    typedef enum logic [2:0] {
        W_IDLE,   // waiting for a pending queue
        W_CMD,    // read control word (+0)
        W_LEN,    // read byte count word (+4)
        W_BUF,    // read buffer address (+8)
        W_NXT,    // read next pointer (+12)
        W_FETCH,  // fetch buffer words into the byte unpacker
        W_DRAIN,  // wait for the last bytes to leave
        W_WB      // write control word back with ownership cleared
    } wstate_t;

    localparam int DESC_OFF_CMD = 0;
    localparam int DESC_OFF_LEN = 4;
    localparam int DESC_OFF_BUF = 8;
    localparam int DESC_OFF_NXT = 12;
endpackage

// File: rtl/txr_start_ctl.sv
// Per-queue ring pointer registers and pending start flags.
// A start that coincides with the walker taking the same queue stays pending,
// so a start seen during a walk is never lost.
module txr_start_ctl #(
    parameter int NQ = 2,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    ptr_we,
    input  logic [AW-1:0]    ptr_wdata,
    input  logic [NQ-1:0]    start,
    input  logic [NQ-1:0]    take,
    output logic [NQ*AW-1:0] ring_ptr,
    output logic [NQ-1:0]    pending
);
    for (genvar g = 0; g < NQ; g++) begin : g_q
        // Ring pointer register of queue g.
        always_ff @(posedge clk) begin
            if (!rst_n)         ring_ptr[g*AW +: AW] <= '0;
            else if (ptr_we[g]) ring_ptr[g*AW +: AW] <= ptr_wdata;
        end

        // Pending flag: a new start wins over the walker taking it.
        always_ff @(posedge clk) begin
            if (!rst_n) pending[g] <= 1'b0;
            else        pending[g] <= start[g] | (pending[g] & ~take[g]);
        end

        // A start pulse is always remembered.
        assert_start_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
            start[g] |=> pending[g]);
    end
endmodule

// File: rtl/txr_byte_out.sv
// Unpacks one loaded word into a byte stream, least significant byte first,
// with valid/ready handshake and a last flag on the final byte of a frame.
// Assumes the loader only loads while no byte is outstanding.
module txr_byte_out #(
    parameter int DW   = 32,
    localparam int NB  = DW / 8,
    localparam int CNTW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   ld_word,
    input  logic [CNTW-1:0] ld_cnt,
    input  logic            ld_last,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_last
);
    logic [DW-1:0]   word_q;
    logic [CNTW-1:0] cnt_q;
    logic            last_q;

    // Hold the word and shift out one byte per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            word_q <= ld_word;
            cnt_q  <= ld_cnt;
            last_q <= ld_last;
        end else if (out_valid && out_ready) begin
            word_q <= word_q >> 8;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign out_valid = (cnt_q != '0);
    assign out_data  = word_q[7:0];
    assign out_last  = last_q && (cnt_q == CNTW'(1));

    // The output holds still while stalled.
    assert_tx_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // The walker never overwrites an unsent byte.
    assert_load_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/txr_walker.sv
// Ring walker: picks the lowest pending queue, visits its descriptors once,
// sends owned buffers through the unpacker, writes back control words and
// pulses the queue's cause bit. Assumes AW == DW == 32 and word-aligned buffers.
module txr_walker
    import txr_pkg::*;
#(
    parameter int NQ         = 2,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int MAX_DESC   = 256,
    parameter int MAX_LEN    = 2048,
    parameter int OWN_BIT    = 31,
    parameter int CAUSE_W    = 4,
    parameter int CAUSE_BASE = 3,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int VW   = $clog2(MAX_DESC + 1),
    localparam int NB   = DW / 8,
    localparam int CNTW = $clog2(NB + 1),
    localparam int LW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NQ-1:0]      pending,
    input  logic [NQ*AW-1:0]   ring_ptr,
    output logic [NQ-1:0]      take,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               bo_busy,
    output logic               bo_load,
    output logic [CNTW-1:0]    bo_cnt,
    output logic               bo_last,
    output logic [CAUSE_W-1:0] cause_pulse,
    output logic               busy
);
    wstate_t         state;
    logic [QW-1:0]   q, sel;
    logic            found;
    logic [AW-1:0]   base, cur, bufp, next_q, off;
    logic [DW-1:0]   cmd;
    logic [LW-1:0]   len, rem;
    logic [VW-1:0]   visits;
    logic [AW-1:0]   adv_ptr;
    logic [VW-1:0]   visits_n;
    logic            adv_stop, send_ok, wb_done;
    logic [CAUSE_W-1:0] cause_set;

    // Lowest-numbered pending queue wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                sel   = QW'(i);
            end
        end
    end

    // Acknowledge the queue being taken.
    always_comb begin
        take = '0;
        if (state == W_IDLE && found) take[sel] = 1'b1;
    end

    assign send_ok  = (len != '0) && (32'(len) < MAX_LEN);
    assign adv_ptr  = (state == W_NXT) ? mem_rdata[AW-1:0] : next_q;
    assign visits_n = visits + 1'b1;
    assign adv_stop = (adv_ptr == base) || (visits_n == VW'(MAX_DESC));
    assign wb_done  = (state == W_WB) && mem_ack;
    assign bo_cnt   = (rem >= LW'(NB)) ? CNTW'(NB) : rem[CNTW-1:0];
    assign bo_last  = (rem <= LW'(NB));
    assign bo_load  = (state == W_FETCH) && mem_ack;
    assign busy     = (state != W_IDLE) || (pending != '0);

    // Memory request decode per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = cmd & ~(DW'(1) << OWN_BIT);
        case (state)
            W_CMD:   begin mem_req = 1'b1; mem_addr = cur + AW'(DESC_OFF_CMD); end
            W_LEN:   begin mem_req = 1'b1; mem_addr = cur + AW'(DESC_OFF_LEN); end
            W_BUF:   begin mem_req = 1'b1; mem_addr = cur + AW'(DESC_OFF_BUF); end
            W_NXT:   begin mem_req = 1'b1; mem_addr = cur + AW'(DESC_OFF_NXT); end
            W_FETCH: begin mem_req = !bo_busy; mem_addr = bufp + off; end
            W_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(DESC_OFF_CMD); end
            default: ;
        endcase
    end

    // Cause bit of queue i sits at CAUSE_BASE - i.
    always_comb begin
        cause_set = '0;
        for (int i = 0; i < NQ; i++)
            if (q == QW'(i)) cause_set[CAUSE_BASE - i] = wb_done;
    end

    // Register the cause pulse one cycle after the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_pulse <= '0;
        else        cause_pulse <= cause_set;
    end

    // Walk sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= W_IDLE;
            q      <= '0;
            base   <= '0;
            cur    <= '0;
            bufp   <= '0;
            next_q <= '0;
            off    <= '0;
            cmd    <= '0;
            len    <= '0;
            rem    <= '0;
            visits <= '0;
        end else begin
            case (state)
                W_IDLE: if (found) begin
                    q      <= sel;
                    base   <= ring_ptr[sel*AW +: AW];
                    cur    <= ring_ptr[sel*AW +: AW];
                    visits <= '0;
                    state  <= W_CMD;
                end
                W_CMD: if (mem_ack) begin
                    cmd   <= mem_rdata;
                    state <= mem_rdata[OWN_BIT] ? W_LEN : W_NXT;
                end
                W_LEN: if (mem_ack) begin
                    len   <= mem_rdata[31:16];
                    state <= W_BUF;
                end
                W_BUF: if (mem_ack) begin
                    bufp  <= mem_rdata[AW-1:0];
                    state <= W_NXT;
                end
                W_NXT: if (mem_ack) begin
                    next_q <= mem_rdata[AW-1:0];
                    if (!cmd[OWN_BIT]) begin
                        cur    <= adv_ptr;
                        visits <= visits_n;
                        state  <= adv_stop ? W_IDLE : W_CMD;
                    end else if (send_ok) begin
                        rem   <= len;
                        off   <= '0;
                        state <= W_FETCH;
                    end else begin
                        state <= W_WB;
                    end
                end
                W_FETCH: if (mem_ack) begin
                    rem <= rem - LW'(bo_cnt);
                    off <= off + AW'(NB);
                    if (bo_last) state <= W_DRAIN;
                end
                W_DRAIN: if (!bo_busy) state <= W_WB;
                W_WB: if (mem_ack) begin
                    cur    <= adv_ptr;
                    visits <= visits_n;
                    state  <= adv_stop ? W_IDLE : W_CMD;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // Requests hold until accepted.
    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // Every write returns the descriptor with ownership cleared.
    assert_wb_own_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

    // Cause pulses are single-bit and follow an accepted write-back.
    assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_pulse));
    assert_cause_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_pulse != '0) |-> $past(mem_req && mem_we && mem_ack));

    // The visit counter never passes the bound.
    assert_visit_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        visits <= VW'(MAX_DESC));

    // No memory traffic when no walk runs.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_IDLE) |-> !mem_req);
endmodule

// File: rtl/txring_engine.sv
// Top of the transmit descriptor ring engine: ring pointers and start flags,
// the ring walker and the byte unpacker for the frame stream.
module txring_engine #(
    parameter int NQ         = 2,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int MAX_DESC   = 256,
    parameter int MAX_LEN    = 2048,
    parameter int OWN_BIT    = 31,
    parameter int CAUSE_W    = 4,
    parameter int CAUSE_BASE = 3,
    localparam int CNTW = $clog2(DW / 8 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NQ-1:0]      ptr_we,
    input  logic [AW-1:0]      ptr_wdata,
    input  logic [NQ-1:0]      start,
    output logic [NQ*AW-1:0]   ring_ptr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic [CAUSE_W-1:0] cause_pulse,
    output logic               busy
);
    logic [NQ-1:0]   pending, take;
    logic            bo_load, bo_last;
    logic [CNTW-1:0] bo_cnt;

    txr_start_ctl #(.NQ(NQ), .AW(AW)) u_start (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .start(start), .take(take), .ring_ptr(ring_ptr), .pending(pending)
    );

    txr_walker #(
        .NQ(NQ), .AW(AW), .DW(DW), .MAX_DESC(MAX_DESC), .MAX_LEN(MAX_LEN),
        .OWN_BIT(OWN_BIT), .CAUSE_W(CAUSE_W), .CAUSE_BASE(CAUSE_BASE)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .pending(pending), .ring_ptr(ring_ptr),
        .take(take), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .bo_busy(tx_valid), .bo_load(bo_load), .bo_cnt(bo_cnt), .bo_last(bo_last),
        .cause_pulse(cause_pulse), .busy(busy)
    );

    txr_byte_out #(.DW(DW)) u_bytes (
        .clk(clk), .rst_n(rst_n), .load(bo_load), .ld_word(mem_rdata),
        .ld_cnt(bo_cnt), .ld_last(bo_last), .out_ready(tx_ready),
        .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last)
    );
endmodule

// File: tb/txring_engine_tb.sv
module txring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ptr_we = '0;
    logic [31:0] ptr_wdata = '0;
    logic [1:0]  start = '0;
    logic [63:0] ring_ptr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic [3:0]  cause_pulse;
    logic        busy;
    logic        mem_allow = 1'b0;

    logic [31:0] mem [0:4095];
    logic [31:0] shd [0:4095];
    logic [31:0] ring_val [0:1];

    logic [7:0]  exp_b [0:4095];
    logic        exp_l [0:4095];
    logic [7:0]  cap_b [0:4095];
    logic        cap_l [0:4095];
    int exp_n, cap_n, exp_rd, rd_cnt, wr_cnt, stray;
    int exp_cause [0:1];
    int got_cause [0:1];
    int checks = 0, errors = 0, cycles = 0;

    always #10 clk = ~clk;

    assign mem_ack   = mem_req & mem_allow;
    assign mem_rdata = mem[mem_addr[13:2]];

    txring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .start(start), .ring_ptr(ring_ptr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .cause_pulse(cause_pulse), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    // Sink and memory responder: set stalls, then log what the next edge completes.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                mem_allow = ($urandom % 4) != 0;
                tx_ready  = ($urandom % 3) != 0;
                if (mem_req && mem_allow) begin
                    if (mem_we) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        rd_cnt++;
                    end
                end
                if (tx_valid && tx_ready && cap_n < 4096) begin
                    cap_b[cap_n] = tx_data;
                    cap_l[cap_n] = tx_last;
                    cap_n++;
                end
                if (cause_pulse[3]) got_cause[0]++;
                if (cause_pulse[2]) got_cause[1]++;
                if (cause_pulse[1:0] != 2'b00) stray++;
            end
        end
    end

    task automatic set_ptr(input int q, input logic [31:0] v);
        @(negedge clk);
        ptr_wdata = v;
        ptr_we = 2'(1 << q);
        ring_val[q] = v;
        @(negedge clk);
        ptr_we = '0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input int len,
                            input logic [31:0] bufa, input logic [31:0] nxt);
        mem[a[13:2]]     = w0;
        mem[a[13:2] + 1] = {16'(len), 16'h5a5a};
        mem[a[13:2] + 2] = bufa;
        mem[a[13:2] + 3] = nxt;
    endtask

    task automatic fill_buf(input logic [31:0] a, input int len);
        for (int i = 0; i < (len + 3) / 4; i++) mem[a[13:2] + 12'(i)] = $urandom;
    endtask

    task automatic begin_scn();
        for (int i = 0; i < 4096; i++) shd[i] = mem[i];
        exp_n = 0; cap_n = 0; exp_rd = 0; rd_cnt = 0; wr_cnt = 0; stray = 0;
        exp_cause[0] = 0; exp_cause[1] = 0; got_cause[0] = 0; got_cause[1] = 0;
    endtask

    // Bench model of one walk on the shadow image.
    task automatic expect_walk(input int q);
        logic [31:0] a, base, w0, bw, bufa;
        int len, visits, idx;
        base = ring_val[q]; a = base; visits = 0;
        do begin
            idx = int'(a[13:2]);
            w0 = shd[idx];
            if (w0[31]) begin
                exp_cause[q]++;
                exp_rd += 4;
                len = int'(shd[idx + 1][31:16]);
                bufa = shd[idx + 2];
                if (len != 0 && len < 2048) begin
                    exp_rd += (len + 3) / 4;
                    for (int b = 0; b < len; b++) begin
                        bw = shd[int'(bufa[13:2]) + b / 4];
                        exp_b[exp_n] = bw[8 * (b % 4) +: 8];
                        exp_l[exp_n] = (b == len - 1);
                        exp_n++;
                    end
                end
                shd[idx] = w0 & 32'h7fff_ffff;
            end else begin
                exp_rd += 2;
            end
            a = shd[idx + 3];
            visits++;
        end while (a != base && visits < 256);
    endtask

    task automatic go(input logic [1:0] st);
        @(negedge clk);
        start = st;
        @(negedge clk);
        start = '0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic end_scn(input string tag);
        int bad, mbad;
        bad = -1;
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && (cap_b[i] != exp_b[i] || cap_l[i] != exp_l[i])) bad = i;
        chk(cap_n == exp_n, {tag, " R5 R6 byte count"}, cap_n, exp_n);
        if (bad >= 0) chk(1'b0, {tag, " R5 R11 byte/last"}, {cap_l[bad], cap_b[bad]}, {exp_l[bad], exp_b[bad]});
        else chk(1'b1, {tag, " R5 R11 byte/last"}, 0, 0);
        chk(rd_cnt == exp_rd, {tag, " R3 R4 R12 read count"}, rd_cnt, exp_rd);
        chk(wr_cnt == exp_cause[0] + exp_cause[1], {tag, " R7 write count"}, wr_cnt, exp_cause[0] + exp_cause[1]);
        chk(got_cause[0] == exp_cause[0], {tag, " R8 cause bit3"}, got_cause[0], exp_cause[0]);
        chk(got_cause[1] == exp_cause[1], {tag, " R8 cause bit2"}, got_cause[1], exp_cause[1]);
        chk(stray == 0, {tag, " R8 stray cause"}, stray, 0);
        mbad = -1;
        for (int i = 0; i < 4096; i++) if (mbad < 0 && mem[i] != shd[i]) mbad = i;
        if (mbad >= 0) chk(1'b0, {tag, " R7 memory image"}, mem[mbad], shd[mbad]);
        else chk(1'b1, {tag, " R7 memory image"}, 0, 0);
    endtask

    initial begin
        logic [31:0] a0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        ring_val[0] = '0; ring_val[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!mem_req && !tx_valid && !busy, "R1 idle outputs", {mem_req, tx_valid, busy}, 0);
        chk(cause_pulse == 4'h0, "R1 cause", cause_pulse, 0);
        chk(ring_ptr == 64'h0, "R1 ring pointers", ring_ptr[31:0] | ring_ptr[63:32], 0);

        // R2 pointer readback
        set_ptr(0, 32'h0000_0040);
        set_ptr(1, 32'h0000_0480);
        chk(ring_ptr[31:0] == 32'h40, "R2 queue0 pointer", ring_ptr[31:0], 32'h40);
        chk(ring_ptr[63:32] == 32'h480, "R2 queue1 pointer", ring_ptr[63:32], 32'h480);

        // Directed: owned short, not owned, zero, 2048, 2047 on queue 0
        put_desc(32'h040, 32'h8000_1234, 5,    32'h1000, 32'h0a0);
        put_desc(32'h0a0, 32'h0000_00ff, 9,    32'h1100, 32'h060);
        put_desc(32'h060, 32'h8000_0001, 0,    32'h1200, 32'h0c0);
        put_desc(32'h0c0, 32'hc000_0000, 2048, 32'h1300, 32'h050);
        put_desc(32'h050, 32'h8abc_0000, 2047, 32'h2800, 32'h040);
        fill_buf(32'h1000, 5); fill_buf(32'h1100, 9); fill_buf(32'h2800, 2047);
        begin_scn(); expect_walk(0);
        go(2'b01); wait_idle(); end_scn("directed R4 R6");

        // Single self-linked descriptor on queue 1: R3 boundary, R8 bit 2
        put_desc(32'h480, 32'h8000_0000, 1, 32'h1400, 32'h480);
        fill_buf(32'h1400, 1);
        begin_scn(); expect_walk(1);
        go(2'b10); wait_idle(); end_scn("single R3");

        // R9: restart q0 and start q1 while q0 walks; q0 served first
        put_desc(32'h040, 32'h8000_0000, 30, 32'h1000, 32'h060);
        put_desc(32'h060, 32'h8000_0000, 20, 32'h1100, 32'h040);
        put_desc(32'h480, 32'h8000_0000, 7,  32'h1400, 32'h480);
        fill_buf(32'h1000, 30); fill_buf(32'h1100, 20); fill_buf(32'h1400, 7);
        begin_scn(); expect_walk(0); expect_walk(0); expect_walk(1);
        go(2'b01); repeat (3) @(negedge clk);
        chk(busy, "R9 walk running", busy, 1);
        go(2'b11); wait_idle(); end_scn("queued R9");

        // R9: both at once, q0 first
        put_desc(32'h040, 32'h8000_0000, 3, 32'h1000, 32'h040);
        put_desc(32'h480, 32'h8000_0000, 4, 32'h1400, 32'h480);
        begin_scn(); expect_walk(0); expect_walk(1);
        go(2'b11); wait_idle(); end_scn("priority R9");

        // R10: chain that never returns to the ring pointer
        set_ptr(0, 32'h0000_0100);
        put_desc(32'h100, 32'h8000_0000, 0, 32'h1000, 32'h110);
        put_desc(32'h110, 32'h8000_0000, 0, 32'h1000, 32'h110);
        begin_scn(); expect_walk(0);
        go(2'b01); wait_idle(); end_scn("bound R10");
        chk(exp_rd == 516, "R10 model visit count", exp_rd, 516);

        // Random rings on both queues
        for (int it = 0; it < 16; it++) begin
            logic [1:0] msk;
            for (int q = 0; q < 2; q++) begin
                int n, r, len, slot, nslot;
                n = 1 + int'($urandom % 8);
                r = int'($urandom % 8);
                for (int i = 0; i < n; i++) begin
                    slot  = (i * 3 + r) % 8;
                    nslot = (((i + 1) % n) * 3 + r) % 8;
                    len = 1 + int'($urandom % 64);
                    if ($urandom % 8 == 0) len = ($urandom % 2 == 0) ? 0 : 2048 + int'($urandom % 100);
                    a0 = 32'(q * 32'h400 + slot * 16);
                    put_desc(a0, ($urandom % 4 != 0) ? ($urandom | 32'h8000_0000) : ($urandom & 32'h7fff_ffff),
                             len, 32'(32'h1000 + q * 32'h800 + slot * 32'h100),
                             32'(q * 32'h400 + nslot * 16));
                    fill_buf(32'(32'h1000 + q * 32'h800 + slot * 32'h100), 64);
                    if (i == 0) set_ptr(q, a0);
                end
            end
            msk = 2'(1 + $urandom % 3);
            begin_scn();
            if (msk[0]) expect_walk(0);
            if (msk[1]) expect_walk(1);
            go(msk); wait_idle(); end_scn("random R3 R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule